// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Unit

This block multiplies an A_W-bit operand by a B_W-bit operand and folds the product into a running sum kept in an output register. The sum is A_W+B_W+16 bits wide, which leaves 16 guard bits above the full product width. At run time, per operation, the caller chooses whether each operand is two's complement or unsigned, and whether the product is added to or subtracted from the sum. A load strobe replaces the sum with a preload value, so the accumulator can be restarted without a reset. A registered flag records an arithmetic overflow and holds it until the next load.

Each operand register can take its value from its parallel input or from a cascade input, and it always presents its contents on a cascade output. A neighbouring element can therefore pass its operand along. The operand register stage and the stage after the multiplier can each be removed by parameter. The accumulator register cannot be removed. All control inputs travel through the same stages as the data, so each control applies to the operands it was presented with.

The operand and result paths are plain registered buses rather than valid/ready streams. A new operation enters on every cycle in which the clock enable is high. Low clock enable is the only way to stall the block, and it freezes every register. There is no back-pressure.

Top module: `mac_unit`

## Requirements
- R1: With clock enable high, an operation presented at the inputs changes `acc_out` exactly IN_REG+PIPE_REG+1 rising edges later; with the defaults that is 3 edges. The new value is the previous sum plus the product.
- R2: When `sub` is 1 the product is subtracted from the sum instead of being added.
- R3: `a_signed`=1 makes A two's complement and 0 makes it unsigned; `b_signed` does the same for B. For example, A=8'hFF gives -1 when signed and 255 when unsigned.
- R4: `acc_out` is A_W+B_W+16 bits wide. The A_W+B_W-bit product is sign-extended into it when either operand is signed and zero-extended when neither is.
- R5: `acc_load`=1 makes the sum take `preload` instead of the arithmetic result, with the same latency as R1.
- R6: `ovf` is set on two's-complement overflow of the sum when either operand is signed. It is set on a carry out (add) or a borrow (subtract) of the sum's MSB when neither operand is signed. Once set it stays set until a load or reset clears it.
- R7: Signed flags, `sub`, `acc_load` and `preload` are delayed with the data. Changing them in the next cycle does not affect an operation already issued.
- R8: `a_ser_sel`=1 loads the A operand register from `a_cas_in` instead of `a_in`, and the same holds for B. `a_cas_out` and `b_cas_out` show the operand register contents one edge after capture.
- R9: While `ce` is 0, no register changes and the inputs are ignored.
- R10: A synchronous `rst` clears every register, so `acc_out`, `ovf` and both cascade outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| a_in | input | A_W | Parallel operand A |
| b_in | input | B_W | Parallel operand B |
| a_signed | input | 1 | Treat A as two's complement |
| b_signed | input | 1 | Treat B as two's complement |
| sub | input | 1 | Subtract the product instead of adding it |
| acc_load | input | 1 | Replace the sum with the preload value |
| preload | input | A_W+B_W+16 | Value loaded by acc_load |
| a_ser_sel | input | 1 | Load operand A from the cascade input |
| b_ser_sel | input | 1 | Load operand B from the cascade input |
| a_cas_in | input | A_W | Cascade input for operand A |
| b_cas_in | input | B_W | Cascade input for operand B |
| a_cas_out | output | A_W | Cascade output for operand A |
| b_cas_out | output | B_W | Cascade output for operand B |
| acc_out | output | A_W+B_W+16 | Accumulated sum |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest condition to reach is overflow. With 16 guard bits, pushing the sum past its range by repeated products would take tens of thousands of operations. The stimulus instead preloads values just below the unsigned top, just below the signed maximum, at the signed minimum, and just above zero. A single product or a single subtraction then crosses the boundary. The flag is then checked to stay set through a neutral operation and to clear on the next load.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Controls that travel with the operands through the first stage
  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic sub;
    logic load;
  } op_ctrl_t;

  // Controls that reach the accumulator after the multiplier
  typedef struct packed {
    logic signed_mode;
    logic sub;
    logic load;
  } acc_ctrl_t;

endpackage

// File: rtl/mac_stage.sv
// Optional register stage for a bundle of bits; EN=0 makes it a wire.
module mac_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac_operand_reg.sv
// Operand register with parallel or cascade source and a cascade output.
module mac_operand_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] par_in,
  input  logic [W-1:0] cas_in,
  input  logic         ser_sel,
  output logic [W-1:0] q,
  output logic [W-1:0] cas_out
);
  logic [W-1:0] src;
  assign src = ser_sel ? cas_in : par_in;

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= src;
      end
      assign q = q_r;

      // R8: cascade selection loads the register from the cascade input
      p_cas_load_r8: assert property (@(posedge clk) disable iff (rst)
        (ce && ser_sel) |=> (cas_out == $past(cas_in)));
    end else begin : g_wire
      assign q = src;
    end
  endgenerate

  assign cas_out = q;
endmodule

// File: rtl/mac_mult.sv
// Combinational multiplier with per-operand signedness.
module mac_mult #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  localparam int PW = A_W + B_W
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic           a_signed,
  input  logic           b_signed,
  output logic [PW-1:0]  prod,
  output logic           signed_mode
);
  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  // Extend each operand to the product width; the low PW bits of the
  // product of the extended values are the exact result in both modes.
  assign a_ext = {{B_W{a_signed & a[A_W-1]}}, a};
  assign b_ext = {{A_W{b_signed & b[B_W-1]}}, b};
  assign prod  = a_ext * b_ext;
  assign signed_mode = a_signed | b_signed;
endmodule

// File: rtl/mac_accum.sv
// Output accumulator register with load, add/subtract and sticky overflow.
module mac_accum #(
  parameter int PW    = 16,
  parameter int ACC_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  mac_pkg::acc_ctrl_t  ctrl,
  input  logic [PW-1:0]       prod,
  input  logic [ACC_W-1:0]    preload,
  output logic [ACC_W-1:0]    acc,
  output logic                ovf
);
  logic [ACC_W-1:0] acc_r;
  logic             ovf_r;
  logic [ACC_W-1:0] ext;
  logic [ACC_W:0]   wide;
  logic [ACC_W-1:0] result;
  logic             s_ovf;
  logic             u_ovf;
  logic             step_ovf;

  assign ext    = {{(ACC_W-PW){ctrl.signed_mode & prod[PW-1]}}, prod};
  assign wide   = ctrl.sub ? ({1'b0, acc_r} - {1'b0, ext})
                           : ({1'b0, acc_r} + {1'b0, ext});
  assign result = wide[ACC_W-1:0];

  // Two's complement: the operand signs that must match or differ,
  // and a result whose sign departs from the running sum's sign
  always_comb begin
    if (ctrl.sub)
      s_ovf = (acc_r[ACC_W-1] != ext[ACC_W-1]) && (result[ACC_W-1] != acc_r[ACC_W-1]);
    else
      s_ovf = (acc_r[ACC_W-1] == ext[ACC_W-1]) && (result[ACC_W-1] != acc_r[ACC_W-1]);
  end
  assign u_ovf    = wide[ACC_W];
  assign step_ovf = ctrl.signed_mode ? s_ovf : u_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r <= '0;
      ovf_r <= 1'b0;
    end else if (ce) begin
      if (ctrl.load) begin
        acc_r <= preload;
        ovf_r <= 1'b0;
      end else begin
        acc_r <= result;
        ovf_r <= ovf_r | step_ovf;
      end
    end
  end

  assign acc = acc_r;
  assign ovf = ovf_r;

  // R5: a load places the preload value in the sum
  p_load_value_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && ctrl.load) |=> (acc == $past(preload)));
  // R6: a load clears the overflow flag
  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && ctrl.load) |=> !ovf);
  // R6: without a load the flag is sticky
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(ce && ctrl.load)) |=> ovf);
  // R9: clock enable low freezes the sum and flag
  p_ce_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(acc) && $stable(ovf)));
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit IN_REG   = 1'b1,
  parameter bit PIPE_REG = 1'b1,
  localparam int PW      = A_W + B_W,
  localparam int ACC_W   = A_W + B_W + 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             sub,
  input  logic             acc_load,
  input  logic [ACC_W-1:0] preload,
  input  logic             a_ser_sel,
  input  logic             b_ser_sel,
  input  logic [A_W-1:0]   a_cas_in,
  input  logic [B_W-1:0]   b_cas_in,
  output logic [A_W-1:0]   a_cas_out,
  output logic [B_W-1:0]   b_cas_out,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf
);
  import mac_pkg::*;

  localparam int S1_W = $bits(op_ctrl_t) + ACC_W;
  localparam int S2_W = $bits(acc_ctrl_t) + ACC_W + PW;

  // ---- stage 1: operands and their controls ----
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  op_ctrl_t       c1_d;
  op_ctrl_t       c1_q;
  logic [ACC_W-1:0] pre1_q;

  mac_operand_reg #(.W(A_W), .EN(IN_REG)) u_opa (
    .clk(clk), .rst(rst), .ce(ce), .par_in(a_in), .cas_in(a_cas_in),
    .ser_sel(a_ser_sel), .q(a_q), .cas_out(a_cas_out));

  mac_operand_reg #(.W(B_W), .EN(IN_REG)) u_opb (
    .clk(clk), .rst(rst), .ce(ce), .par_in(b_in), .cas_in(b_cas_in),
    .ser_sel(b_ser_sel), .q(b_q), .cas_out(b_cas_out));

  assign c1_d = '{a_signed: a_signed, b_signed: b_signed, sub: sub, load: acc_load};

  mac_stage #(.W(S1_W), .EN(IN_REG)) u_ctl1 (
    .clk(clk), .rst(rst), .ce(ce),
    .d({c1_d, preload}), .q({c1_q, pre1_q}));

  // ---- multiplier ----
  logic [PW-1:0] prod_d;
  logic          mode_d;

  mac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
    .a(a_q), .b(b_q), .a_signed(c1_q.a_signed), .b_signed(c1_q.b_signed),
    .prod(prod_d), .signed_mode(mode_d));

  // ---- stage 2: product pipeline ----
  acc_ctrl_t        c2_d;
  acc_ctrl_t        c2_q;
  logic [PW-1:0]    prod_q;
  logic [ACC_W-1:0] pre2_q;

  assign c2_d = '{signed_mode: mode_d, sub: c1_q.sub, load: c1_q.load};

  mac_stage #(.W(S2_W), .EN(PIPE_REG)) u_pipe (
    .clk(clk), .rst(rst), .ce(ce),
    .d({c2_d, pre1_q, prod_d}), .q({c2_q, pre2_q, prod_q}));

  // ---- stage 3: accumulator (always present) ----
  mac_accum #(.PW(PW), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .ce(ce), .ctrl(c2_q), .prod(prod_q),
    .preload(pre2_q), .acc(acc_out), .ovf(ovf));

  // R10: reset clears the visible state
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !ovf));
endmodule

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  localparam int A_W   = 8;
  localparam int B_W   = 8;
  localparam int ACC_W = A_W + B_W + 16;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b1;
  logic [A_W-1:0] a_in = '0;
  logic [B_W-1:0] b_in = '0;
  logic a_signed = 1'b0, b_signed = 1'b0, sub = 1'b0, acc_load = 1'b0;
  logic [ACC_W-1:0] preload = '0;
  logic a_ser_sel = 1'b0, b_ser_sel = 1'b0;
  logic [A_W-1:0] a_cas_in = '0;
  logic [B_W-1:0] b_cas_in = '0;
  logic [A_W-1:0] a_cas_out;
  logic [B_W-1:0] b_cas_out;
  logic [ACC_W-1:0] acc_out;
  logic ovf;

  int checks = 0;
  int errors = 0;

  logic [ACC_W-1:0] m_acc = '0;
  logic             m_ovf = 1'b0;

  always #4 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a_in), .b_in(b_in),
    .a_signed(a_signed), .b_signed(b_signed), .sub(sub), .acc_load(acc_load),
    .preload(preload), .a_ser_sel(a_ser_sel), .b_ser_sel(b_ser_sel),
    .a_cas_in(a_cas_in), .b_cas_in(b_cas_in), .a_cas_out(a_cas_out),
    .b_cas_out(b_cas_out), .acc_out(acc_out), .ovf(ovf));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Reference arithmetic from the requirements (R3, R4, R6)
  task automatic model(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                       input bit sa, input bit sb, input bit sb_sub,
                       input bit ld, input logic [ACC_W-1:0] pre);
    longint pa, pb, p, cur, r, top_s, bot_s, top_u;
    if (ld) begin
      m_acc = pre;
      m_ovf = 1'b0;
      return;
    end
    pa = sa ? longint'($signed(a)) : longint'(a);
    pb = sb ? longint'($signed(b)) : longint'(b);
    p  = pa * pb;
    top_s = (longint'(1) <<< (ACC_W-1)) - 1;
    bot_s = -(longint'(1) <<< (ACC_W-1));
    top_u = (longint'(1) <<< ACC_W) - 1;
    if (sa || sb) begin
      cur = longint'($signed(m_acc));
      r = sb_sub ? cur - p : cur + p;
      if (r > top_s || r < bot_s) m_ovf = 1'b1;
    end else begin
      cur = longint'(m_acc);
      r = sb_sub ? cur - p : cur + p;
      if (r > top_u || r < 0) m_ovf = 1'b1;
    end
    m_acc = r[ACC_W-1:0];
  endtask

  task automatic op(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                    input bit sa, input bit sb, input bit sb_sub,
                    input bit ld, input logic [ACC_W-1:0] pre);
    @(negedge clk);
    a_in = a; b_in = b; a_signed = sa; b_signed = sb; sub = sb_sub;
    acc_load = ld; preload = pre;
    model(a, b, sa, sb, sb_sub, ld, pre);
  endtask

  task automatic flush();
    for (int i = 0; i < LAT; i++) op('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    m_acc = '0; m_ovf = 1'b0;
    check("R10 acc after reset", acc_out, 0);
    check("R10 ovf after reset", ovf, 0);
    check("R10 a_cas_out after reset", a_cas_out, 0);
    check("R10 b_cas_out after reset", b_cas_out, 0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    op(8'd12, 8'd10, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // R1: two edges later the sum must not yet have moved
    @(negedge clk); a_in = '0; b_in = '0;
    @(negedge clk);
    check("R1 sum unchanged before latency", acc_out, 0);
    @(negedge clk);
    check("R1 sum after latency", acc_out, 120);
    op(8'd255, 8'd255, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    flush();
    check("R4 unsigned full product zero-extended", acc_out, m_acc);
  endtask

  task automatic t_signed();
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd1000);
    op(8'hFF, 8'd3, 1'b1, 1'b0, 1'b0, 1'b0, '0);   // -1 * 3
    flush();
    check("R3 signed A times unsigned B", acc_out, 32'd997);
    op(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, '0);  // -1 * -1
    flush();
    check("R3 both signed", acc_out, 32'd998);
    op(8'd2, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, '0);   // 2 * -128
    flush();
    check("R4 negative product sign-extended", acc_out, 32'd742);
  endtask

  task automatic t_subtract();
    op(8'd5, 8'd7, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    flush();
    check("R2 subtract product", acc_out, 32'd707);
    check("R2 no borrow", ovf, 0);
  endtask

  task automatic t_back_to_back();
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0001_0000);
    op(8'hF0, 8'd4, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    op(8'd9, 8'd9, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    op(8'h81, 8'h02, 1'b1, 1'b1, 1'b1, 1'b0, '0);
    op(8'd200, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    flush();
    check("R7 controls aligned per operation", acc_out, m_acc);
    check("R7 ovf clear", ovf, m_ovf);
  endtask

  task automatic t_load();
    op(8'd3, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    op(8'd50, 8'd50, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF);
    flush();
    check("R5 load overrides product", acc_out, 32'hDEAD_BEEF);
  endtask

  task automatic t_ovf_unsigned();
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF00);
    op(8'd255, 8'd255, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    flush();
    check("R6 unsigned carry sets ovf", ovf, 1);
    check("R6 wrapped sum", acc_out, m_acc);
    op(8'd1, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    flush();
    check("R6 ovf sticky", ovf, 1);
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd5);
    flush();
    check("R6 load clears ovf", ovf, 0);
    op(8'd2, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    flush();
    check("R6 unsigned borrow sets ovf", ovf, 1);
    check("R6 borrow wrapped sum", acc_out, 32'hFFFF_FFFF);
  endtask

  task automatic t_ovf_signed();
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h7FFF_FFF0);
    op(8'd127, 8'd127, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    flush();
    check("R6 signed positive overflow", ovf, 1);
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h8000_0000);
    op(8'd1, 8'd1, 1'b1, 1'b1, 1'b1, 1'b0, '0);
    flush();
    check("R6 signed subtract overflow", ovf, 1);
    check("R6 signed wrap value", acc_out, 32'h7FFF_FFFF);
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    op(8'd1, 8'd1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    flush();
    check("R6 signed -1 plus 1 no overflow", ovf, 0);
    check("R6 signed -1 plus 1 sum", acc_out, 0);
  endtask

  task automatic t_serial();
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    @(negedge clk);
    a_in = 8'd99; a_cas_in = 8'd5; a_ser_sel = 1'b1;
    b_in = 8'd3;  b_cas_in = 8'd77; b_ser_sel = 1'b0;
    acc_load = 1'b0; a_signed = 1'b0; b_signed = 1'b0; sub = 1'b0;
    model(8'd5, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R8 a_cas_out from cascade input", a_cas_out, 8'd5);
    check("R8 b_cas_out from parallel input", b_cas_out, 8'd3);
    a_ser_sel = 1'b0; a_cas_in = '0; b_cas_in = '0; a_in = '0; b_in = '0;
    repeat (LAT-1) @(negedge clk);
    check("R8 product uses cascade operand", acc_out, 32'd15);
  endtask

  task automatic t_clock_enable();
    op('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd100);
    flush();
    op(8'd10, 8'd10, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    ce = 1'b0;
    a_in = 8'd200; b_in = 8'd200; acc_load = 1'b1; preload = 32'h1234_5678;
    a_ser_sel = 1'b1; a_cas_in = 8'd33;
    repeat (5) @(negedge clk);
    check("R9 sum frozen", acc_out, 32'd100);
    check("R9 operand register frozen", a_cas_out, 8'd10);
    a_in = '0; b_in = '0; acc_load = 1'b0; preload = '0;
    a_ser_sel = 1'b0; a_cas_in = '0;
    ce = 1'b1;
    flush();
    check("R9 held operation completes after resume", acc_out, 32'd200);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_signed();
    t_subtract();
    t_back_to_back();
    t_load();
    t_ovf_unsigned();
    t_ovf_signed();
    t_serial();
    t_clock_enable();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule